// File: doc/BRIEF.md
# Eight-Bit Prescaled Timer with Two Compare Channels

This block is an 8-bit up-counter driven by a selectable clock divider. Two compare values are held alongside it. The block raises a flag on counter wrap and on each compare match. Each flag can be routed to an interrupt request through its own enable. Two waveform pins can each be left idle or made to flip state on their channel's match.

The counter runs in one of two modes. In free-run mode it covers the full 0 to 255 range. In clear-on-match mode it returns to zero after reaching compare value A, so compare value A alone sets the period. Software programs the block with simple register writes. An interrupt controller clears a flag by pulsing the matching acknowledge line, and software can also clear flags by writing ones to a dedicated address.

Top module: `tmr8_timer`

## Requirements
- R1: Control bits [2:0] select the divider: 001 = every clock, 010 = every 8, 011 = every 64, 100 = every 256, 101 = every 1024. After a control write, the first advance comes D clocks after the write edge, and later advances come every D clocks.
- R2: Divider code 000 freezes the counter, and the divider restarts from zero. After the timer is restarted, the first advance again comes a full D clocks after the write.
- R3: Divider codes 110 and 111 freeze the counter in the same way as 000.
- R4: In free-run mode (control bit [3] = 0) the counter steps by one per advance and goes from 255 to 0. That wrap sets flag bit 0, the overflow flag. The wrap from 255 to 0 sets this flag in either mode.
- R5: In clear-on-match mode (control bit [3] = 1), the counter returns to 0 on the advance that follows the one where it equals compare A. The period is compare A + 1 advances. Compare B never sets the period.
- R6: Flag bit 1 sets on an advance where the counter equals compare A. Flag bit 2 sets on an advance where the counter equals compare B.
- R7: Pin mode 01 (control [5:4] for pin A, [7:6] for pin B) flips the pin on each advance where its channel matches. A pin starts at 0.
- R8: Pin modes 00, 10 and 11 hold the pin at 0.
- R9: Writing to address 4 clears each flag whose data bit is 1. Flags whose data bit is 0 are left as they are.
- R10: A high bit on irq_ack_i clears that flag. If a set event and a clear arrive in the same cycle, the set wins.
- R11: irq_o[i] is flag i ANDed with enable bit i, and the enables are written at address 3.
- R12: The register addresses are: 0 control, 1 compare A, 2 compare B, 3 enables, 4 flag clear. A write takes effect on the next clock. After reset, every register, the counter, the flags and the pins are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | AW | Register address |
| wr_data_i | input | CW | Write data |
| irq_ack_i | input | 3 | Per-flag service acknowledge |
| cnt_o | output | CW | Counter value |
| flags_o | output | 3 | Flags: bit 0 overflow, bit 1 match A, bit 2 match B |
| irq_o | output | 3 | Enabled interrupt requests |
| wave_a_o | output | 1 | Channel A waveform pin |
| wave_b_o | output | 1 | Channel B waveform pin |

## Verification
The pin toggle property assumes there is no register write in the cycle of the match, because a control write in that cycle could change the pin mode just as the pin flips. The bench therefore writes registers only while the timer is stopped, or at moments when no match can fall on the write edge. The counter-stepping properties assume the counter only changes on an advance. This holds because the interface offers no way to load the counter, and the bench clears the counter only through reset.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

    localparam int unsigned NFLAG  = 3;
    localparam int unsigned FL_OVF = 0;
    localparam int unsigned FL_CMA = 1;
    localparam int unsigned FL_CMB = 2;
    localparam int unsigned NCH    = 2;

    localparam int unsigned ADDR_CTRL = 0;
    localparam int unsigned ADDR_CMPA = 1;
    localparam int unsigned ADDR_CMPB = 2;
    localparam int unsigned ADDR_MASK = 3;
    localparam int unsigned ADDR_FCLR = 4;

    // Largest division ratio is 1024, so the divider needs 10 bits.
    localparam int unsigned MAX_DIV = 1024;
    localparam int unsigned PRE_W   = $clog2(MAX_DIV);

    typedef enum logic [1:0] {
        PIN_OFF  = 2'b00,
        PIN_TOG  = 2'b01,
        PIN_RSV2 = 2'b10,
        PIN_RSV3 = 2'b11
    } pin_mode_e;

    typedef enum logic [2:0] {
        CS_STOP    = 3'd0,
        CS_DIV1    = 3'd1,
        CS_DIV8    = 3'd2,
        CS_DIV64   = 3'd3,
        CS_DIV256  = 3'd4,
        CS_DIV1024 = 3'd5,
        CS_RSV6    = 3'd6,
        CS_RSV7    = 3'd7
    } clk_sel_e;

    // Layout of the control register: [7:6] pin B, [5:4] pin A, [3] clear-on-match, [2:0] divider.
    typedef struct packed {
        pin_mode_e modb;
        pin_mode_e moda;
        logic      ctc;
        clk_sel_e  clksel;
    } ctrl_t;

    function automatic logic cs_running(clk_sel_e cs);
        return (cs inside {CS_DIV1, CS_DIV8, CS_DIV64, CS_DIV256, CS_DIV1024});
    endfunction

    // Low-bit mask that the free-running divider must fill for an advance.
    function automatic logic [PRE_W-1:0] div_mask(clk_sel_e cs);
        logic [PRE_W-1:0] m;
        case (cs)
            CS_DIV1:    m = PRE_W'(0);
            CS_DIV8:    m = PRE_W'(7);
            CS_DIV64:   m = PRE_W'(63);
            CS_DIV256:  m = PRE_W'(255);
            CS_DIV1024: m = PRE_W'(1023);
            default:    m = PRE_W'(0);
        endcase
        return m;
    endfunction

endpackage

// File: rtl/tmr8_regs.sv
module tmr8_regs
    import tmr8_pkg::*;
#(
    parameter int unsigned CW = 8,
    parameter int unsigned AW = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic [AW-1:0]    wr_addr_i,
    input  logic [CW-1:0]    wr_data_i,
    output ctrl_t            ctrl_o,
    output logic [CW-1:0]    cmpa_o,
    output logic [CW-1:0]    cmpb_o,
    output logic [NFLAG-1:0] mask_o,
    output logic [NFLAG-1:0] fclr_o
);

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CW-1:0]    cmpa;
        logic [CW-1:0]    cmpb;
        logic [NFLAG-1:0] mask;
    } regs_t;

    regs_t st_d, st_q;

    logic sel_ctrl, sel_cmpa, sel_cmpb, sel_mask, sel_fclr;

    always_comb begin
        sel_ctrl = wr_en_i && (wr_addr_i == AW'(ADDR_CTRL));
        sel_cmpa = wr_en_i && (wr_addr_i == AW'(ADDR_CMPA));
        sel_cmpb = wr_en_i && (wr_addr_i == AW'(ADDR_CMPB));
        sel_mask = wr_en_i && (wr_addr_i == AW'(ADDR_MASK));
        sel_fclr = wr_en_i && (wr_addr_i == AW'(ADDR_FCLR));

        st_d = st_q;
        if (sel_ctrl) st_d.ctrl = ctrl_t'(wr_data_i[7:0]);
        if (sel_cmpa) st_d.cmpa = wr_data_i;
        if (sel_cmpb) st_d.cmpb = wr_data_i;
        if (sel_mask) st_d.mask = wr_data_i[NFLAG-1:0];

        // The clear is a one-cycle strobe and is not stored.
        fclr_o = sel_fclr ? wr_data_i[NFLAG-1:0] : '0;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign ctrl_o = st_q.ctrl;
    assign cmpa_o = st_q.cmpa;
    assign cmpb_o = st_q.cmpb;
    assign mask_o = st_q.mask;

endmodule

// File: rtl/tmr8_presc.sv
module tmr8_presc
    import tmr8_pkg::*;
#(
    parameter int unsigned PW = PRE_W
) (
    input  logic     clk_i,
    input  logic     rst_ni,
    input  clk_sel_e clksel_i,
    output logic     tick_o
);

    typedef struct packed {
        logic [PW-1:0] div;
    } pre_t;

    pre_t          st_d, st_q;
    logic          run;
    logic [PW-1:0] mask;

    always_comb begin
        run  = cs_running(clksel_i);
        mask = PW'(div_mask(clksel_i));
        st_d = st_q;
        if (!run) st_d.div = '0;
        else      st_d.div = st_q.div + PW'(1);
        // All masks are 2^k-1, so the free wrap of the divider keeps the spacing.
        tick_o = run && ((st_q.div & mask) == mask);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

endmodule

// File: rtl/tmr8_core.sv
module tmr8_core
    import tmr8_pkg::*;
#(
    parameter int unsigned CW = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             ctc_i,
    input  logic [CW-1:0]    cmpa_i,
    input  logic [CW-1:0]    cmpb_i,
    input  logic [NFLAG-1:0] clr_i,
    output logic [CW-1:0]    cnt_o,
    output logic [NFLAG-1:0] flags_o,
    output logic [NCH-1:0]   match_o
);

    localparam logic [CW-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CW-1:0]    cnt;
        logic [NFLAG-1:0] flags;
    } core_t;

    core_t            st_d, st_q;
    logic             hit_a, hit_b, at_max, at_top;
    logic [NFLAG-1:0] ev;

    always_comb begin
        hit_a  = tick_i && (st_q.cnt == cmpa_i);
        hit_b  = tick_i && (st_q.cnt == cmpb_i);
        at_max = (st_q.cnt == CNT_MAX);
        at_top = ctc_i && (st_q.cnt == cmpa_i);

        ev         = '0;
        ev[FL_OVF] = tick_i && at_max;
        ev[FL_CMA] = hit_a;
        ev[FL_CMB] = hit_b;

        st_d = st_q;
        if (tick_i) begin
            if (at_top || at_max) st_d.cnt = '0;
            else                  st_d.cnt = st_q.cnt + CW'(1);
        end
        // Set events take priority over clears landing in the same cycle.
        st_d.flags = ev | (st_q.flags & ~clr_i);

        match_o = {hit_b, hit_a};
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cnt_o   = st_q.cnt;
    assign flags_o = st_q.flags;

endmodule

// File: rtl/tmr8_wave.sv
module tmr8_wave
    import tmr8_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_ni,
    input  pin_mode_e mode_i,
    input  logic      match_i,
    output logic      pin_o
);

    typedef struct packed {
        logic tog;
    } wave_t;

    wave_t st_d, st_q;
    logic  live;

    always_comb begin
        live = (mode_i == PIN_TOG);
        st_d = st_q;
        if (live) st_d.tog = st_q.tog ^ match_i;
        else      st_d.tog = 1'b0;
        pin_o = live && st_q.tog;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

endmodule

// File: rtl/tmr8_timer.sv
module tmr8_timer
    import tmr8_pkg::*;
#(
    parameter int unsigned CW = 8,
    parameter int unsigned AW = 3
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [CW-1:0] wr_data_i,
    input  logic [2:0]    irq_ack_i,
    output logic [CW-1:0] cnt_o,
    output logic [2:0]    flags_o,
    output logic [2:0]    irq_o,
    output logic          wave_a_o,
    output logic          wave_b_o
);

    ctrl_t            ctrl_w;
    logic [CW-1:0]    cmpa_w, cmpb_w;
    logic [NFLAG-1:0] mask_w, fclr_w, clr_w;
    logic             tick_w;
    logic [NCH-1:0]   match_w;
    logic [NCH-1:0]   pin_w;
    pin_mode_e        mode_w [NCH];

    tmr8_regs #(.CW(CW), .AW(AW)) u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .ctrl_o    (ctrl_w),
        .cmpa_o    (cmpa_w),
        .cmpb_o    (cmpb_w),
        .mask_o    (mask_w),
        .fclr_o    (fclr_w)
    );

    tmr8_presc #(.PW(PRE_W)) u_presc (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .clksel_i (ctrl_w.clksel),
        .tick_o   (tick_w)
    );

    assign clr_w = fclr_w | irq_ack_i;

    tmr8_core #(.CW(CW)) u_core (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .tick_i  (tick_w),
        .ctc_i   (ctrl_w.ctc),
        .cmpa_i  (cmpa_w),
        .cmpb_i  (cmpb_w),
        .clr_i   (clr_w),
        .cnt_o   (cnt_o),
        .flags_o (flags_o),
        .match_o (match_w)
    );

    assign mode_w[0] = ctrl_w.moda;
    assign mode_w[1] = ctrl_w.modb;

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        tmr8_wave u_wave (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .mode_i  (mode_w[g]),
            .match_i (match_w[g]),
            .pin_o   (pin_w[g])
        );
    end

    assign irq_o    = flags_o & mask_w;
    assign wave_a_o = pin_w[0];
    assign wave_b_o = pin_w[1];

endmodule

// File: rtl/tmr8_timer_chk.sv
module tmr8_timer_chk #(
    parameter int unsigned CW = 8
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          wr_en_i,
    input logic          tick,
    input logic          ctc,
    input logic [2:0]    clksel,
    input logic [1:0]    moda,
    input logic [CW-1:0] cmpa,
    input logic [CW-1:0] cmpb,
    input logic [CW-1:0] cnt_o,
    input logic [2:0]    flags_o,
    input logic          wave_a_o
);

    assert_stop_notick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clksel == 3'd0) |-> !tick);

    assert_rsv_notick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clksel == 3'd6 || clksel == 3'd7) |-> !tick);

    assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick |=> $stable(cnt_o));

    assert_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick && !ctc && cnt_o != '1) |=> (cnt_o == $past(cnt_o) + CW'(1)));

    assert_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick && cnt_o == '1) |=> (cnt_o == '0 && flags_o[0]));

    assert_ctc_top_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick && ctc && cnt_o == cmpa) |=> (cnt_o == '0));

    assert_flag_a_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick && cnt_o == cmpa) |=> flags_o[1]);

    assert_flag_b_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick && cnt_o == cmpb) |=> flags_o[2]);

    assert_toggle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick && cnt_o == cmpa && moda == 2'b01 && !wr_en_i) |=> (wave_a_o != $past(wave_a_o)));

endmodule

bind tmr8_timer tmr8_timer_chk #(.CW(CW)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .tick     (tick_w),
    .ctc      (ctrl_w.ctc),
    .clksel   (ctrl_w.clksel),
    .moda     (ctrl_w.moda),
    .cmpa     (cmpa_w),
    .cmpb     (cmpb_w),
    .cnt_o    (cnt_o),
    .flags_o  (flags_o),
    .wave_a_o (wave_a_o)
);

// File: tb/tmr8_timer_bench.sv
`timescale 1ns/1ps
module tmr8_timer_bench;

    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [2:0] wr_addr_i = 3'd0;
    logic [7:0] wr_data_i = 8'd0;
    logic [2:0] irq_ack_i = 3'd0;
    logic [7:0] cnt_o;
    logic [2:0] flags_o, irq_o;
    logic       wave_a_o, wave_b_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk_i = ~clk_i;

    tmr8_timer u_tmr8_timer (
        .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i), .irq_ack_i(irq_ack_i), .cnt_o(cnt_o), .flags_o(flags_o),
        .irq_o(irq_o), .wave_a_o(wave_a_o), .wave_b_o(wave_b_o)
    );

    // Vector fields: divider[43:41] clear-on-match[40] cmpA[39:32] cmpB[31:24] pinA[23:22] pinB[21:20] cycles[19:0]
    localparam int NV = 10;
    localparam logic [43:0] VEC [NV] = '{
        {3'd1, 1'b0, 8'd10,  8'd20,  2'd1, 2'd1, 20'd5},
        {3'd1, 1'b0, 8'd10,  8'd20,  2'd1, 2'd1, 20'd300},
        {3'd1, 1'b1, 8'd9,   8'd3,   2'd1, 2'd1, 20'd25},
        {3'd2, 1'b0, 8'd2,   8'd200, 2'd1, 2'd0, 20'd30},
        {3'd3, 1'b0, 8'd0,   8'd255, 2'd1, 2'd1, 20'd20000},
        {3'd4, 1'b1, 8'd3,   8'd5,   2'd1, 2'd1, 20'd2000},
        {3'd5, 1'b0, 8'd1,   8'd1,   2'd0, 2'd1, 20'd2100},
        {3'd6, 1'b0, 8'd1,   8'd2,   2'd1, 2'd1, 20'd100},
        {3'd0, 1'b0, 8'd1,   8'd2,   2'd1, 2'd1, 20'd50},
        {3'd1, 1'b1, 8'd255, 8'd128, 2'd1, 2'd2, 20'd600}
    };

    function automatic int div_of(int cs);
        case (cs)
            1: return 1;
            2: return 8;
            3: return 64;
            4: return 256;
            5: return 1024;
            default: return 0;
        endcase
    endfunction

    // Number of advances at which the pre-advance count equals c.
    function automatic int nmatch(int t, int p, int c);
        if (c >= p || t <= c) return 0;
        return (t - 1 - c) / p + 1;
    endfunction

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk_i);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        @(posedge clk_i);
        @(negedge clk_i);
        wr_en_i = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk_i);
        rst_ni = 1'b0; wr_en_i = 1'b0; irq_ack_i = 3'd0;
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int cs, ctc, ca, cb, ma, mb, n, t, p, mA, mB, mO, efl;
        logic [43:0] v;

        // R12: reset state
        do_reset();
        @(negedge clk_i);
        chk("R12 cnt", int'(cnt_o), 0);
        chk("R12 flags", int'(flags_o), 0);
        chk("R12 irq", int'(irq_o), 0);
        chk("R7 pins reset", int'({wave_a_o, wave_b_o}), 0);

        // Table walk: R1 R3 R4 R5 R6 R7 R8 R11
        for (int i = 0; i < NV; i++) begin
            v  = VEC[i];
            cs = int'(v[43:41]); ctc = int'(v[40]);
            ca = int'(v[39:32]); cb = int'(v[31:24]);
            ma = int'(v[23:22]); mb = int'(v[21:20]); n = int'(v[19:0]);
            do_reset();
            wr(3'd1, v[39:32]);
            wr(3'd2, v[31:24]);
            wr(3'd3, 8'd7);
            wr(3'd0, {v[21:20], v[23:22], v[40], v[43:41]});
            repeat (n) @(negedge clk_i);
            t  = (div_of(cs) == 0) ? 0 : n / div_of(cs);
            p  = (ctc != 0) ? ca + 1 : 256;
            mO = nmatch(t, p, 255);
            mA = nmatch(t, p, ca);
            mB = nmatch(t, p, cb);
            efl = ((mO > 0) ? 1 : 0) + ((mA > 0) ? 2 : 0) + ((mB > 0) ? 4 : 0);
            chk("R1/R3/R4/R5 count", int'(cnt_o), t % p);
            chk("R4/R6 flags", int'(flags_o), efl);
            chk("R11 irq all enabled", int'(irq_o), efl);
            chk("R7/R8 pin A", int'(wave_a_o), (ma == 1) ? (mA % 2) : 0);
            chk("R7/R8 pin B", int'(wave_b_o), (mb == 1) ? (mB % 2) : 0);
        end

        // R9, R10, R11: clearing and gating
        do_reset();
        wr(3'd1, 8'd3);
        wr(3'd2, 8'd4);
        wr(3'd0, 8'h01);
        repeat (10) @(negedge clk_i);
        chk("R6 both match flags", int'(flags_o), 6);
        chk("R11 masked off", int'(irq_o), 0);
        wr(3'd3, 8'd2);
        chk("R11 mask A only", int'(irq_o), 2);
        wr(3'd4, 8'h04);
        chk("R9 write-one clears B only", int'(flags_o), 2);
        irq_ack_i = 3'b010;
        @(posedge clk_i);
        @(negedge clk_i);
        irq_ack_i = 3'b000;
        chk("R10 ack clears A", int'(flags_o), 0);

        // R10: set wins over a same-cycle acknowledge
        do_reset();
        wr(3'd1, 8'd5);
        wr(3'd2, 8'd200);
        wr(3'd0, 8'h01);
        repeat (5) @(negedge clk_i);
        irq_ack_i = 3'b010;
        @(posedge clk_i);
        @(negedge clk_i);
        irq_ack_i = 3'b000;
        chk("R10 set beats ack", int'(flags_o[1]), 1);
        chk("R1 count at match", int'(cnt_o), 6);

        // R2: stop holds and restarts the divider
        do_reset();
        wr(3'd0, 8'h02);
        repeat (12) @(negedge clk_i);
        chk("R1 div8 one advance", int'(cnt_o), 1);
        wr(3'd0, 8'h00);
        repeat (20) @(negedge clk_i);
        chk("R2 held while stopped", int'(cnt_o), 1);
        wr(3'd0, 8'h02);
        repeat (7) @(negedge clk_i);
        chk("R2 divider restarted", int'(cnt_o), 1);
        @(negedge clk_i);
        chk("R2 first advance after 8", int'(cnt_o), 2);

        // R3: reserved divider code holds the count
        wr(3'd0, 8'h07);
        repeat (30) @(negedge clk_i);
        chk("R3 code 111 holds", int'(cnt_o), 2);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule